// File: doc/BRIEF.md
# Link Integrity Supervisor for a 10 Mb/s Twisted-Pair Transceiver

This block keeps watch over a twisted-pair link. On the transmit side it asks the line driver for a short idle pulse at a fixed spacing whenever no frame is going out. A frame restarts the spacing, so pulses fill only the gaps between frames. On the receive side it accepts an incoming idle pulse only when the pulse follows the previous one within an allowed spacing window. It also treats the start of a received frame as proof of a live link.

If no accepted pulse and no frame arrives within the loss window, the block declares the link failed and closes the gates on the transmit and receive data paths. Idle pulses keep going out while the link is failed, so the far end can still see this station. A second pulse at a correct spacing after the first, or any new frame, reopens the paths. A disable input turns the whole function off. In that mode no pulses are sent, the paths stay open and the fail flag stays low.

All times are counted in cycles of the block clock and set by parameters. The defaults assume a 100 MHz clock.

Top module: `link_integrity`

## Requirements
- R1: While the transmitter is idle and link test is enabled, `link_pulse_req` rises once every `PERIOD_CLKS` cycles.
- R2: Each pulse on `link_pulse_req` stays high for exactly `PULSE_CLKS` cycles, unless it is cut short by `tx_busy`.
- R3: `link_pulse_req` is low in every cycle after a clock edge that saw `tx_busy` high. After `tx_busy` is last seen high, the next pulse rises on the `PERIOD_CLKS`-th following edge.
- R4: After reset, with link test enabled, the block is in the fail state: `link_fail` is 1 and both path enables are 0.
- R5: A strobe on `rx_link_pulse` counts as valid only if its spacing d (clock edges since the previous strobe, valid or not) satisfies `MIN_GAP_CLKS <= d <= MAX_GAP_CLKS`. The first strobe after reset is never valid. A valid strobe moves the block to the pass state on the edge that samples it. An invalid strobe changes neither the state nor the loss timer.
- R6: In the pass state, if no activity occurs, `link_fail` rises on the (`LOSS_CLKS`+1)-th edge after the last activity edge. Activity means a valid strobe, or an edge that samples `rx_frame_active` high.
- R7: A rising edge of `rx_frame_active` moves the block to the pass state on the edge that samples it. While the frame lasts, the link cannot fail.
- R8: In the fail state `tx_path_en` and `rx_path_en` are 0 and link pulses are still requested. In the pass state both enables are 1.
- R9: While `link_test_dis` is 1, `link_fail` is 0, both enables are 1 and no link pulse is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_test_dis | input | 1 | 1 turns the link integrity function off |
| tx_busy | input | 1 | A frame is being transmitted |
| rx_frame_active | input | 1 | A received frame is in progress |
| rx_link_pulse | input | 1 | One-cycle strobe per detected incoming link pulse |
| link_pulse_req | output | 1 | Request to the line driver to emit a link pulse |
| link_fail | output | 1 | 1 in the fail state, 0 when the link is good |
| tx_path_en | output | 1 | Transmit data path gate |
| rx_path_en | output | 1 | Receive data path gate |

## Verification
The assertions assume the following about the inputs:
- `rx_link_pulse` is a synchronous one-cycle strobe.
- `MIN_GAP_CLKS` is at least 2.
- `PULSE_CLKS` is below `PERIOD_CLKS`.
- All inputs change only between clock edges.

The bench drives every input at the falling clock edge and never holds a strobe for more than one cycle. It never overlaps a strobe with a frame. It draws strobe spacings from four bands: too short, in the window, too long, and beyond the loss window. It also draws frame lengths and idle gaps at random, and toggles `tx_busy` at random, all within those assumptions.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  typedef enum logic {
    LNK_PASS = 1'b0,
    LNK_FAIL = 1'b1
  } lnk_state_e;

  // Counter width able to hold values 0..limit.
  function automatic int unsigned cnt_width(input int unsigned limit);
    int unsigned w;
    w = $clog2(limit + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Spacing rule for incoming link pulses: gap counted in clock edges.
  function automatic logic spacing_ok(input int unsigned gap,
                                      input int unsigned lo,
                                      input int unsigned hi);
    return (gap >= lo) && (gap <= hi);
  endfunction

endpackage

// File: rtl/lnk_pulse_gen.sv
module lnk_pulse_gen #(
  parameter int unsigned PERIOD_CLKS = 1_600_000,
  parameter int unsigned PULSE_CLKS  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dis,
  input  logic tx_busy,
  output logic pulse_req
);
  import lnk_pkg::*;

  localparam int unsigned IW = cnt_width(PERIOD_CLKS - 1);
  localparam int unsigned PW = cnt_width(PULSE_CLKS);
  localparam logic [IW-1:0] IC_LAST = IW'(PERIOD_CLKS - 1);
  localparam logic [PW-1:0] PW_LOAD = PW'(PULSE_CLKS);

  logic [IW-1:0] ic_q;
  logic [PW-1:0] pw_q;
  logic          hold;
  logic          interval_done;

  assign hold          = dis | tx_busy;
  assign interval_done = (ic_q == IC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_q <= '0;
      pw_q <= '0;
    end else if (hold) begin
      ic_q <= '0;
      pw_q <= '0;
    end else if (interval_done) begin
      ic_q <= '0;
      pw_q <= PW_LOAD;
    end else begin
      ic_q <= ic_q + 1'b1;
      if (pw_q != '0) pw_q <= pw_q - 1'b1;
    end
  end

  assign pulse_req = (pw_q != '0);

  // checker: length of the current high run
  logic [PW:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_run_q <= '0;
    else if (pulse_req) hi_run_q <= hi_run_q + 1'b1;
    else                hi_run_q <= '0;
  end

  p_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run_q <= (PW + 1)'(PULSE_CLKS));

  p_busy_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> !pulse_req);

endmodule

// File: rtl/lnk_rx_qual.sv
module lnk_rx_qual #(
  parameter int unsigned MIN_GAP_CLKS = 300_000,
  parameter int unsigned MAX_GAP_CLKS = 7_500_000,
  parameter int unsigned LOSS_CLKS    = 9_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dis,
  input  logic rx_lp,
  input  logic rx_active,
  output logic valid_lp,
  output logic frame_start,
  output logic activity,
  output logic loss_exp
);
  import lnk_pkg::*;

  localparam int unsigned GW = cnt_width(MAX_GAP_CLKS);
  localparam int unsigned LW = cnt_width(LOSS_CLKS);
  localparam logic [GW-1:0] GC_MAX = GW'(MAX_GAP_CLKS);
  localparam logic [LW-1:0] LC_MAX = LW'(LOSS_CLKS);

  logic [GW-1:0] gap_q;   // edges since previous strobe, minus one, saturating
  logic [LW-1:0] loss_q;  // edges since last activity, saturating
  logic          act_q;

  assign frame_start = rx_active & ~act_q;
  assign valid_lp    = rx_lp &&
                       spacing_ok(32'(gap_q) + 32'd1, MIN_GAP_CLKS, MAX_GAP_CLKS);
  assign activity    = valid_lp | frame_start;
  assign loss_exp    = (loss_q == LC_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= GC_MAX;
      loss_q <= LC_MAX;
      act_q  <= 1'b0;
    end else begin
      act_q <= rx_active;
      if (rx_lp)                gap_q <= '0;
      else if (gap_q != GC_MAX) gap_q <= gap_q + 1'b1;
      if (dis || activity || rx_active) loss_q <= '0;
      else if (loss_q != LC_MAX)        loss_q <= loss_q + 1'b1;
    end
  end

  generate
    if (MIN_GAP_CLKS > 1) begin : g_early_chk
      p_early_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_lp && $past(rx_lp)) |-> !valid_lp);
    end
  endgenerate

  p_frame_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |=> !loss_exp);

endmodule

// File: rtl/lnk_state_ctl.sv
module lnk_state_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dis,
  input  logic activity,
  input  logic loss_exp,
  output logic link_fail,
  output logic tx_en,
  output logic rx_en
);
  import lnk_pkg::*;

  lnk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (dis)           state_d = LNK_PASS;
    else if (activity) state_d = LNK_PASS;
    else if (loss_exp) state_d = LNK_FAIL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LNK_FAIL;
    else        state_q <= state_d;
  end

  assign link_fail = (state_q == LNK_FAIL) && !dis;
  assign tx_en     = !link_fail;
  assign rx_en     = !link_fail;

  p_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loss_exp && !activity && !dis) |=> (state_q == LNK_FAIL));

  p_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (activity && !dis) |=> (state_q == LNK_PASS));

endmodule

// File: rtl/link_integrity.sv
module link_integrity #(
  parameter int unsigned PERIOD_CLKS  = 1_600_000,
  parameter int unsigned PULSE_CLKS   = 10,
  parameter int unsigned MIN_GAP_CLKS = 300_000,
  parameter int unsigned MAX_GAP_CLKS = 7_500_000,
  parameter int unsigned LOSS_CLKS    = 9_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_test_dis,
  input  logic tx_busy,
  input  logic rx_frame_active,
  input  logic rx_link_pulse,
  output logic link_pulse_req,
  output logic link_fail,
  output logic tx_path_en,
  output logic rx_path_en
);

  logic valid_lp;
  logic frame_start;
  logic activity;
  logic loss_exp;

  lnk_pulse_gen #(
    .PERIOD_CLKS(PERIOD_CLKS),
    .PULSE_CLKS (PULSE_CLKS)
  ) u_pgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .dis      (link_test_dis),
    .tx_busy  (tx_busy),
    .pulse_req(link_pulse_req)
  );

  lnk_rx_qual #(
    .MIN_GAP_CLKS(MIN_GAP_CLKS),
    .MAX_GAP_CLKS(MAX_GAP_CLKS),
    .LOSS_CLKS   (LOSS_CLKS)
  ) u_rxq (
    .clk        (clk),
    .rst_n      (rst_n),
    .dis        (link_test_dis),
    .rx_lp      (rx_link_pulse),
    .rx_active  (rx_frame_active),
    .valid_lp   (valid_lp),
    .frame_start(frame_start),
    .activity   (activity),
    .loss_exp   (loss_exp)
  );

  lnk_state_ctl u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .dis      (link_test_dis),
    .activity (activity),
    .loss_exp (loss_exp),
    .link_fail(link_fail),
    .tx_en    (tx_path_en),
    .rx_en    (rx_path_en)
  );

  p_dis_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(link_test_dis) |-> !link_pulse_req);

  p_start_recovers_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !link_test_dis) |=> !link_fail);

endmodule

// File: tb/link_integrity_tb_top.sv
module link_integrity_tb_top;
  localparam int P  = 160;
  localparam int W  = 10;
  localparam int MN = 20;
  localparam int MX = 250;
  localparam int LS = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dis = 1'b0, tx_busy = 1'b0, rx_act = 1'b0, rx_lp = 1'b0;
  logic lp, lfail, txen, rxen;

  link_integrity #(.PERIOD_CLKS(P), .PULSE_CLKS(W), .MIN_GAP_CLKS(MN),
                   .MAX_GAP_CLKS(MX), .LOSS_CLKS(LS)) dut_i (
    .clk(clk), .rst_n(rst_n), .link_test_dis(dis), .tx_busy(tx_busy),
    .rx_frame_active(rx_act), .rx_link_pulse(rx_lp),
    .link_pulse_req(lp), .link_fail(lfail), .tx_path_en(txen), .rx_path_en(rxen));

  always #5 clk = ~clk;

  int    vec = 0, bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input string req, input longint act, input longint exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit gap_valid(input longint d, input bit have_prev);
    return have_prev && d >= MN && d <= MX;
  endfunction

  // pulse monitor, samples 2 ns after each rising edge
  bit     lp_prev = 0, rise_ok = 0, trunc = 0;
  longint rise_cyc = 0;
  int     hi_len = 0, fail_rises = 0, dis_pulses = 0;
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (tx_busy && lp) chk("R3 pulse while busy", lp, 0);
      if (dis && lp) dis_pulses++;
      if (tx_busy || dis) begin rise_ok = 0; if (lp_prev) trunc = 1; end
      if (lp && !lp_prev) begin
        if (rise_ok) chk("R1 pulse period", cyc - rise_cyc, P);
        if (lfail) fail_rises++;
        rise_cyc = cyc; rise_ok = 1; hi_len = 0; trunc = 0;
      end
      if (lp) hi_len++;
      if (!lp && lp_prev && !trunc) chk("R2 pulse width", hi_len, W);
      lp_prev = lp;
    end
  end

  // receive-side model state
  bit     exp_fail;
  bit     have_prev = 0;
  longint prev_s = 0, last_act = 0;

  task automatic send_lp();
    longint s, d;
    bit v, pre;
    s = cyc;
    pre = exp_fail || (s >= last_act + LS + 1);
    chk("R6 state before strobe", lfail, pre);
    d = s - prev_s;
    v = gap_valid(d, have_prev);
    rx_lp = 1'b1;
    @(negedge clk);
    rx_lp = 1'b0;
    if (v) begin exp_fail = 0; last_act = s + 1; end
    else exp_fail = exp_fail || (s + 1 >= last_act + LS + 1);
    chk(v ? "R5 valid strobe" : "R5 invalid strobe ignored", lfail, exp_fail);
    chk("R8 tx gate", txen, !exp_fail);
    chk("R8 rx gate", rxen, !exp_fail);
    prev_s = s; have_prev = 1;
  endtask

  task automatic send_frame(input int len);
    bit pre;
    pre = exp_fail || (cyc >= last_act + LS + 1);
    chk("R6 state before frame", lfail, pre);
    rx_act = 1'b1;
    @(negedge clk);
    chk("R7 frame start recovers", lfail, 0);
    repeat (len - 1) @(negedge clk);
    chk("R7 no fail during frame", lfail, 0);
    rx_act = 1'b0;
    exp_fail = 0;
    last_act = cyc;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin : main
    int n;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h1A2B);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    chk("R4 link_fail after reset", lfail, 1);
    chk("R4 tx gate after reset", txen, 0);
    chk("R4 rx gate after reset", rxen, 0);
    exp_fail = 1;

    // R3: busy holds off pulses, restart measured from last busy edge
    tx_busy = 1'b1;
    repeat (30) @(negedge clk);
    tx_busy = 1'b0;
    n = 0;
    while (!lp && n < 4 * P) begin @(negedge clk); if (!lp) n++; end
    chk("R3 first pulse after busy", n, P - 1);
    chk("R8 pulse sent while failed", lfail, 1);

    // R5 directed: first strobe invalid, short spacing invalid, MN valid
    send_lp();
    repeat (MN - 2) @(negedge clk);
    send_lp();
    repeat (MN - 1) @(negedge clk);
    send_lp();
    chk("R5 pass after window spacing", lfail, 0);

    // R6: exact loss time
    n = 0;
    while (!lfail && n < 4 * LS) begin @(negedge clk); if (!lfail) n++; end
    chk("R6 loss delay", n, LS);
    exp_fail = 1;
    chk("R8 tx gate closed", txen, 0);

    // R7: frame recovers and holds, then loss from frame end
    send_frame(LS + 100);
    n = 0;
    while (!lfail && n < 4 * LS) begin @(negedge clk); if (!lfail) n++; end
    chk("R7 loss counted from frame end", n, LS);
    exp_fail = 1;
    chk("R8 pulses continued in fail", fail_rises > 0, 1);

    // random phase
    for (int i = 0; i < 220; i++) begin
      int kind, d;
      kind = int'($urandom % 5);
      tx_busy = ($urandom % 4) == 0;
      case (kind)
        0: d = 1 + int'($urandom % (MN - 1));
        1, 2: d = MN + int'($urandom % (MX - MN + 1));
        3: d = MX + 1 + int'($urandom % (LS - MX));
        default: d = 1 + int'($urandom % 50);
      endcase
      if (kind == 4) begin
        repeat (d) @(negedge clk);
        send_frame(1 + int'($urandom % 60));
      end else begin
        while (cyc < prev_s + d) @(negedge clk);
        if (($urandom % 8) == 0) repeat (LS + 2) @(negedge clk);
        send_lp();
      end
    end
    tx_busy = 1'b0;

    // R9: disable
    @(negedge clk);
    dis = 1'b1;
    for (int k = 0; k < 12; k++) begin
      repeat (80) @(negedge clk);
      chk("R9 link_fail low when disabled", lfail, 0);
      chk("R9 tx gate open when disabled", txen, 1);
      chk("R9 rx gate open when disabled", rxen, 1);
    end
    chk("R9 no pulses when disabled", dis_pulses, 0);
    dis = 1'b0;
    @(negedge clk);
    chk("R9 pass state after enable", lfail, 0);
    repeat (2 * P) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule